// File: doc/BRIEF.md
# Group Interrupt Flag with Acknowledge Barrier

This block gives a group of cooperating elements one shared interrupt flag. Any element can raise its request line. The flag sets on the rising edge of the combined request. It stays set until every element has taken part in an acknowledge barrier. The flag never reaches a processor as a hardware interrupt. Instead, each element polls it through its own status bit whenever it chooses.

Each element has a single status bit. A per-element select line decides whether that bit carries the barrier-ready signal, which comes from barrier logic outside this block, or the interrupt flag. Because each element has its own select, one element can check for a pending interrupt while the others keep seeing barrier ready.

Request, acknowledge and select inputs arrive asynchronously. They pass through a synchronizer of configurable depth before they are used. The barrier-ready input is already in the block's clock domain.

Top module: `grp_irq_unit`

## Requirements
- R1: A rising edge on the request line of any single element, or of several at once, sets the pending flag. The flag is the OR of all request lines, and the rise is seen at `irq_pending_o` three clock edges after the input changes, with a synchronizer depth of two.
- R2: The flag is set by a rise of the combined request, not by its level. If a request stays high after the flag has cleared, the flag stays clear. After the combined request falls and rises again, the flag sets again.
- R3: For element i, `status_o[i]` shows the interrupt flag when `sel_i[i]` is 1 and shows `barrier_rdy_i` when `sel_i[i]` is 0.
- R4: Select is independent for each element. Changing one element's select bit changes only that element's status bit.
- R5: The flag clears only when all bits of `ack_n_i` are low, which is the acknowledge barrier (active-low, 0 = acknowledging). While any element holds its acknowledge high, the flag stays set.
- R6: If a rise of the combined request arrives in the same cycle as a complete acknowledge barrier, the flag is set, not cleared.
- R7: During and after reset the flag is 0. Every element's status bit shows barrier ready whatever its select input is, until the synchronized select has been sampled after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_EL | Per-element interrupt request, asynchronous |
| ack_n_i | input | NUM_EL | Per-element acknowledge, active low, asynchronous |
| sel_i | input | NUM_EL | Per-element status select: 1 = interrupt flag, 0 = barrier ready |
| barrier_rdy_i | input | 1 | Barrier-ready signal from the external barrier logic |
| status_o | output | NUM_EL | Per-element status bit |
| irq_pending_o | output | 1 | Shared pending interrupt flag |

## Verification
The hardest case to reach from the ports is a fresh request rise that lands in exactly the same cycle as a completed acknowledge barrier. Without that cycle, set priority cannot be told apart from clear priority. The bench first leaves the flag set and all requests low. It then drives one element's request high and every acknowledge low at the same falling clock edge. Both pass through synchronizers of equal depth, so they meet the flag register in the same cycle. The flag is sampled one cycle later, to see that the set won and that the clear followed once no new edge was present.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    typedef struct packed {
        logic flag;
        logic req_any_prev;
    } irqb_state_t;

    localparam irqb_state_t IRQB_STATE_RST = '{flag: 1'b0, req_any_prev: 1'b0};

endpackage

// File: rtl/irqb_sync.sv
module irqb_sync #(
    parameter int                 W       = 4,
    parameter int                 STAGES  = 2,
    parameter logic [W-1:0]       RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stg_q[k] <= RST_VAL;
            end
        end else begin
            for (int k = 0; k < STAGES; k++) begin
                stg_q[k] <= stg_d[k];
            end
        end
    end

    assign dout = stg_q[LAST];

endmodule

// File: rtl/irqb_flag.sv
module irqb_flag
    import irqb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_s,
    input  logic [N-1:0] ackn_s,
    output logic         flag
);
    irqb_state_t st_d, st_q;
    logic req_any;
    logic ack_all;
    logic req_rise;

    always_comb begin
        req_any  = |req_s;
        ack_all  = ~|ackn_s;
        req_rise = req_any & ~st_q.req_any_prev;
        st_d              = st_q;
        st_d.req_any_prev = req_any;
        if (req_rise) begin
            st_d.flag = 1'b1;
        end else if (ack_all) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= IRQB_STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // Any new rise of the combined request sets the flag, even against a full acknowledge (R1, R6).
    assert_set_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_any && !st_q.req_any_prev) |=> flag);

    // Without a rise the flag cannot go from clear to set (R2).
    assert_no_level_retrigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(req_any && !st_q.req_any_prev)) |=> !flag);

    // A set flag survives any cycle in which one acknowledge is still high (R5).
    assert_hold_until_barrier_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && (ackn_s != '0)) |=> flag);

    // A complete acknowledge barrier with no rise clears the flag (R5).
    assert_clear_on_barrier_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ackn_s == '0) && !(req_any && !st_q.req_any_prev)) |=> !flag);

endmodule

// File: rtl/irqb_route.sv
module irqb_route #(
    parameter int N = 4
) (
    input  logic         flag,
    input  logic         rdy,
    input  logic [N-1:0] sel_s,
    output logic [N-1:0] status
);
    for (genvar i = 0; i < N; i++) begin : g_el
        assign status[i] = sel_s[i] ? flag : rdy;
    end

endmodule

// File: rtl/grp_irq_unit.sv
module grp_irq_unit #(
    parameter int NUM_EL     = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EL-1:0] req_i,
    input  logic [NUM_EL-1:0] ack_n_i,
    input  logic [NUM_EL-1:0] sel_i,
    input  logic              barrier_rdy_i,
    output logic [NUM_EL-1:0] status_o,
    output logic              irq_pending_o
);
    localparam logic [NUM_EL-1:0] ALL_ZERO = '0;
    localparam logic [NUM_EL-1:0] ALL_ONE  = '1;

    logic [NUM_EL-1:0] req_s;
    logic [NUM_EL-1:0] ackn_s;
    logic [NUM_EL-1:0] sel_s;
    logic              flag;

    irqb_sync #(.W(NUM_EL), .STAGES(SYNC_DEPTH), .RST_VAL(ALL_ZERO)) u_sync_req (
        .clk(clk), .rst_n(rst_n), .din(req_i), .dout(req_s)
    );

    irqb_sync #(.W(NUM_EL), .STAGES(SYNC_DEPTH), .RST_VAL(ALL_ONE)) u_sync_ack (
        .clk(clk), .rst_n(rst_n), .din(ack_n_i), .dout(ackn_s)
    );

    irqb_sync #(.W(NUM_EL), .STAGES(SYNC_DEPTH), .RST_VAL(ALL_ZERO)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .din(sel_i), .dout(sel_s)
    );

    irqb_flag #(.N(NUM_EL)) u_flag (
        .clk(clk), .rst_n(rst_n), .req_s(req_s), .ackn_s(ackn_s), .flag(flag)
    );

    irqb_route #(.N(NUM_EL)) u_route (
        .flag(flag), .rdy(barrier_rdy_i), .sel_s(sel_s), .status(status_o)
    );

    assign irq_pending_o = flag;

    // Elements not selecting the flag see barrier ready on their status bit (R3, R7).
    assert_unselected_shows_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s == '0) |-> (status_o == {NUM_EL{barrier_rdy_i}}));

endmodule

// File: tb/sim_grp_irq_unit.sv
module sim_grp_irq_unit;
    localparam int N    = 4;
    localparam int ROWS = 10;

    // Row fields: req[20:17] ackn[16:13] sel[12:9] rdy[8] exp_flag[7] exp_status[6:3] req_tag[2:0]
    localparam logic [20:0] TBL [ROWS] = '{
        {4'b0000, 4'b1111, 4'b0000, 1'b1, 1'b0, 4'b1111, 3'd3}, // R3 idle, ready shown
        {4'b0010, 4'b1111, 4'b0000, 1'b0, 1'b1, 4'b0000, 3'd1}, // R1 one request sets
        {4'b0010, 4'b1111, 4'b0101, 1'b0, 1'b1, 4'b0101, 3'd4}, // R4 per-element select
        {4'b0010, 4'b1000, 4'b0101, 1'b0, 1'b1, 4'b0101, 3'd5}, // R5 partial ack holds
        {4'b0010, 4'b0000, 4'b0101, 1'b0, 1'b0, 4'b0000, 3'd5}, // R5 full barrier clears
        {4'b0010, 4'b1111, 4'b1111, 1'b0, 1'b0, 4'b0000, 3'd2}, // R2 held level no retrigger
        {4'b0000, 4'b1111, 4'b1111, 1'b1, 1'b0, 4'b0000, 3'd3}, // R3 flag shown, not ready
        {4'b1001, 4'b1111, 4'b0011, 1'b0, 1'b1, 4'b0011, 3'd1}, // R1 two requests at once
        {4'b1000, 4'b0000, 4'b0011, 1'b0, 1'b0, 4'b0000, 3'd5}, // R5 clear, no new rise
        {4'b0000, 4'b1111, 4'b0000, 1'b1, 1'b0, 4'b1111, 3'd3}  // R3 back to ready
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] ack_n_i = '1;
    logic [N-1:0] sel_i = '0;
    logic         barrier_rdy_i = 1'b0;
    logic [N-1:0] status_o;
    logic         irq_pending_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    grp_irq_unit #(.NUM_EL(N), .SYNC_DEPTH(2)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_n_i(ack_n_i), .sel_i(sel_i),
        .barrier_rdy_i(barrier_rdy_i), .status_o(status_o), .irq_pending_o(irq_pending_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        // R7: reset state, select inputs ignored while reset holds them
        sel_i = '1;
        barrier_rdy_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 flag in reset", {7'd0, irq_pending_o}, 8'd0);
        check("R7 status shows ready in reset", {4'd0, status_o}, 8'h0F);
        rst_n = 1'b1;
        sel_i = '0;
        repeat (4) @(negedge clk);
        check("R7 flag after reset", {7'd0, irq_pending_o}, 8'd0);

        for (int r = 0; r < ROWS; r++) begin
            req_i         = TBL[r][20:17];
            ack_n_i       = TBL[r][16:13];
            sel_i         = TBL[r][12:9];
            barrier_rdy_i = TBL[r][8];
            repeat (5) @(negedge clk);
            check($sformatf("R%0d row %0d flag", TBL[r][2:0], r),
                  {7'd0, irq_pending_o}, {7'd0, TBL[r][7]});
            check($sformatf("R%0d row %0d status", TBL[r][2:0], r),
                  {4'd0, status_o}, {4'd0, TBL[r][6:3]});
        end

        // R2: a fresh rise after a fall sets again
        req_i = 4'b0100;
        repeat (5) @(negedge clk);
        check("R2 new rise sets again", {7'd0, irq_pending_o}, 8'd1);
        req_i = 4'b0000;
        repeat (5) @(negedge clk);
        check("R5 flag held after request drops", {7'd0, irq_pending_o}, 8'd1);

        // R6: rise and full barrier meet in the same cycle
        req_i   = 4'b0001;
        ack_n_i = 4'b0000;
        repeat (3) @(negedge clk);
        check("R6 set wins over clear", {7'd0, irq_pending_o}, 8'd1);
        @(negedge clk);
        check("R5 barrier clears next cycle", {7'd0, irq_pending_o}, 8'd0);

        // R4: one element selects flag, others keep ready
        ack_n_i = '1;
        req_i = 4'b0000;
        repeat (3) @(negedge clk);
        req_i = 4'b0010;
        repeat (5) @(negedge clk);
        sel_i = 4'b1000;
        barrier_rdy_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 only element 3 shows flag", {4'd0, status_o}, 8'h08);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule